// File: doc/BRIEF.md
# Codec Register Configuration Sequencer

This block keeps an audio codec configured by driving a small, fixed list of register writes into the command address and command data inputs of a serial audio link controller. The controller sends whatever pair is on those inputs in each link frame. The sequencer steps to the next pair each time the controller's frame strobe pulses.

The list covers master volume, headphone volume, PCM output volume, record source select and record gain. After the last entry the sequencer returns to the first one and keeps cycling. Because the writes repeat every few frames, a codec that powers up late or loses its settings after a glitch is reconfigured within a handful of frames, with no host involvement.

The record source, either microphone or line input, is picked at elaboration by a parameter. The attenuation and gain levels are also parameters.

Top module: `codec_cfg_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe, the outputs present entry 0: address 0x02 with the master volume word.
- R2: The address and data hold their values in every clock cycle in which `frame_strobe` is low.
- R3: A clock edge that samples `frame_strobe` high moves to the next entry. The outputs show that entry in the following cycle. The entries run in this order: 0x02 master, 0x04 headphone, 0x18 PCM out, 0x1A record select, 0x1C record gain.
- R4: A strobe taken while entry 4 (0x1C) is presented returns the sequencer to entry 0 (0x02).
- R5: The record select entry carries data 0x0404 when `USE_LINE_IN` is 1 and 0x0000 when it is 0.
- R6: All volume and gain words have bit 15 (mute) clear. Master and headphone carry `{2'b0, L[5:0], 2'b0, R[5:0]}`, and both channels default to 16, giving 0x1010. PCM out carries `{3'b0, L[4:0], 3'b0, R[4:0]}` with a default of 8, giving 0x0808. Record gain carries `{4'b0, L[3:0], 4'b0, R[3:0]}` with a default of 8, giving 0x0808.
- R7: When the strobe stays high for several consecutive cycles, the sequencer advances one entry per cycle. This includes crossing the wrap.
- R8: A low level on `rst_n` returns the outputs to entry 0 at once, without waiting for a clock edge, from any point in the sequence.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse from the link controller at the start of each frame |
| reg_addr | output | 8 | Codec register address for the link controller's command input |
| reg_data | output | 16 | Codec register write data for the link controller's command input |

## Verification
Two functions can fall in the same cycle: stepping to the next entry and wrapping back to the start both happen when a strobe is sampled while the record gain entry is presented. The bench provokes this with single strobes, and also with a strobe held high across the wrap, so that the wrap lands between two ordinary advances. A scoreboard predicts the (address, data) pair for every cycle, for a line-input instance and a microphone instance side by side. A mismatch at the wrap or at the record select entry is reported against its requirement.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   localparam int ADDR_W      = 8;
   localparam int DATA_W      = 16;
   localparam int ENTRY_COUNT = 5;
   localparam int IDX_W       = $clog2(ENTRY_COUNT);

   localparam logic [ADDR_W-1:0] A_MASTER   = 8'h02;
   localparam logic [ADDR_W-1:0] A_HEADPH   = 8'h04;
   localparam logic [ADDR_W-1:0] A_PCM_OUT  = 8'h18;
   localparam logic [ADDR_W-1:0] A_REC_SEL  = 8'h1A;
   localparam logic [ADDR_W-1:0] A_REC_GAIN = 8'h1C;

   localparam logic [DATA_W-1:0] SRC_MIC  = 16'h0000;
   localparam logic [DATA_W-1:0] SRC_LINE = 16'h0404;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } cfg_word_t;
endpackage

// File: rtl/cfg_index.sv
module cfg_index
   import cfg_seq_pkg::*;
#(
   parameter int COUNT = ENTRY_COUNT,
   localparam int W    = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] idx
);
   localparam logic [W-1:0] LAST = W'(COUNT - 1);

   initial begin
      if (COUNT < 2) $error("cfg_index: COUNT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           idx <= '0;
      else if (step)        idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(idx));
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && idx != LAST) |=> idx == $past(idx) + 1'b1);
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && idx == LAST) |=> idx == '0);
   assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST);
endmodule

// File: rtl/cfg_table.sv
module cfg_table
   import cfg_seq_pkg::*;
#(
   parameter bit USE_LINE_IN = 1'b1,
   parameter int MASTER_ATTN = 16,
   parameter int HP_ATTN     = 16,
   parameter int PCM_ATTN    = 8,
   parameter int REC_GAIN    = 8
) (
   input  logic [IDX_W-1:0] idx,
   output cfg_word_t        word
);
   localparam logic [DATA_W-1:0] MASTER_W = {2'b00, 6'(MASTER_ATTN), 2'b00, 6'(MASTER_ATTN)};
   localparam logic [DATA_W-1:0] HP_W     = {2'b00, 6'(HP_ATTN),     2'b00, 6'(HP_ATTN)};
   localparam logic [DATA_W-1:0] PCM_W    = {3'b000, 5'(PCM_ATTN),   3'b000, 5'(PCM_ATTN)};
   localparam logic [DATA_W-1:0] GAIN_W   = {4'h0, 4'(REC_GAIN),     4'h0, 4'(REC_GAIN)};

   initial begin
      if (MASTER_ATTN < 0 || MASTER_ATTN > 63) $error("cfg_table: MASTER_ATTN out of range");
      if (HP_ATTN < 0 || HP_ATTN > 63)         $error("cfg_table: HP_ATTN out of range");
      if (PCM_ATTN < 0 || PCM_ATTN > 31)       $error("cfg_table: PCM_ATTN out of range");
      if (REC_GAIN < 0 || REC_GAIN > 15)       $error("cfg_table: REC_GAIN out of range");
   end

   logic [DATA_W-1:0] src_word;

   generate
      if (USE_LINE_IN) begin : g_line
         assign src_word = SRC_LINE;
      end else begin : g_mic
         assign src_word = SRC_MIC;
      end
   endgenerate

   always_comb begin
      case (idx)
         3'd0:    word = '{addr: A_MASTER,   data: MASTER_W};
         3'd1:    word = '{addr: A_HEADPH,   data: HP_W};
         3'd2:    word = '{addr: A_PCM_OUT,  data: PCM_W};
         3'd3:    word = '{addr: A_REC_SEL,  data: src_word};
         3'd4:    word = '{addr: A_REC_GAIN, data: GAIN_W};
         default: word = '{addr: A_MASTER,   data: MASTER_W};
      endcase
   end
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
   import cfg_seq_pkg::*;
#(
   parameter bit USE_LINE_IN = 1'b1,
   parameter int MASTER_ATTN = 16,
   parameter int HP_ATTN     = 16,
   parameter int PCM_ATTN    = 8,
   parameter int REC_GAIN    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_strobe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_data
);
   logic [IDX_W-1:0] idx;
   cfg_word_t        word;

   initial begin
      if (ADDR_W != 8 || DATA_W != 16) $error("codec_cfg_seq: command widths must be 8/16");
   end

   cfg_index #(.COUNT(ENTRY_COUNT)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (frame_strobe),
      .idx   (idx)
   );

   cfg_table #(
      .USE_LINE_IN (USE_LINE_IN),
      .MASTER_ATTN (MASTER_ATTN),
      .HP_ATTN     (HP_ATTN),
      .PCM_ATTN    (PCM_ATTN),
      .REC_GAIN    (REC_GAIN)
   ) u_table (
      .idx  (idx),
      .word (word)
   );

   assign reg_addr = word.addr;
   assign reg_data = word.data;

   assert_unmuted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != A_REC_SEL) |-> !reg_data[15]);
   assert_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_REC_SEL) |-> (reg_data == (USE_LINE_IN ? SRC_LINE : SRC_MIC)));
   assert_wrap_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && reg_addr == A_REC_GAIN) |=> reg_addr == A_MASTER);
endmodule

// File: tb/codec_cfg_seq_tb.sv
module codec_cfg_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_strobe = 1'b0;
   logic [7:0]  addr_line, addr_mic;
   logic [15:0] data_line, data_mic;

   int checks = 0;
   int errors = 0;
   int exp_idx = 0;
   bit done = 1'b0;

   typedef struct {
      logic [23:0] line_v;
      logic [23:0] mic_v;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   codec_cfg_seq #(.USE_LINE_IN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
      .reg_addr(addr_line), .reg_data(data_line));

   codec_cfg_seq #(.USE_LINE_IN(1'b0)) u_dut_mic (
      .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
      .reg_addr(addr_mic), .reg_data(data_mic));

   function automatic logic [23:0] entry(input int i, input bit line);
      case (i)
         0: return {8'h02, 16'h1010};
         1: return {8'h04, 16'h1010};
         2: return {8'h18, 16'h0808};
         3: return {8'h1A, line ? 16'h0404 : 16'h0000};
         default: return {8'h1C, 16'h0808};
      endcase
   endfunction

   task automatic check_now(input string tag);
      checks++;
      if ({addr_line, data_line} !== entry(exp_idx, 1'b1)) begin
         errors++;
         $display("FAIL %s line: got %h expected %h", tag, {addr_line, data_line}, entry(exp_idx, 1'b1));
      end
      checks++;
      if ({addr_mic, data_mic} !== entry(exp_idx, 1'b0)) begin
         errors++;
         $display("FAIL %s mic: got %h expected %h", tag, {addr_mic, data_mic}, entry(exp_idx, 1'b0));
      end
   endtask

   task automatic push_exp(input string tag);
      exp_t e;
      e.line_v = entry(exp_idx, 1'b1);
      e.mic_v  = entry(exp_idx, 1'b0);
      e.tag    = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares a little after each falling edge
   always @(negedge clk) begin
      #2;
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if ({addr_line, data_line} !== e.line_v) begin
            errors++;
            $display("FAIL %s line: got %h expected %h", e.tag, {addr_line, data_line}, e.line_v);
         end
         checks++;
         if ({addr_mic, data_mic} !== e.mic_v) begin
            errors++;
            $display("FAIL %s mic: got %h expected %h", e.tag, {addr_mic, data_mic}, e.mic_v);
         end
      end
   end

   // strobe held high for n cycles: one advance per cycle
   task automatic strobe_run(input int n, input string tag);
      @(negedge clk);
      frame_strobe = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         exp_idx = (exp_idx == 4) ? 0 : exp_idx + 1;
         if (i == n - 1) frame_strobe = 1'b0;
         push_exp(tag);
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         push_exp(tag);
      end
   endtask

   initial begin
      #5;
      check_now("R1 in reset");
      #40;
      @(negedge clk);
      rst_n = 1'b1;
      idle(3, "R1 after reset");

      for (int k = 0; k < 5; k++) begin
         strobe_run(1, "R3 single step");
         idle(2, "R2 hold");
      end
      // back at entry 0 after passing the wrap (R4)
      for (int k = 0; k < 4; k++) strobe_run(1, "R5 R6 walk to last");
      strobe_run(1, "R4 wrap single strobe");
      idle(1, "R2 hold after wrap");

      strobe_run(3, "R7 burst");
      strobe_run(4, "R7 burst across wrap R4");
      idle(2, "R2 hold after burst");

      // asynchronous reset mid-sequence (R8)
      strobe_run(2, "R3 advance before reset");
      @(negedge clk);
      #5;
      rst_n = 1'b0;
      exp_idx = 0;
      #2;
      check_now("R8 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R1 restart");
      strobe_run(1, "R3 after restart");
      idle(2, "R2 final hold");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule